// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block drives an I2C bus as a transmit-only master. A host issues bus commands by writing two control bits, `cmd_busy` and `cmd_ss`. The {1,0} pair opens a transfer with a start condition. The {0,0} pair closes it with a stop condition. Every other pair is ignored.

Bytes arrive on a valid/ready port. Each accepted byte is parked in a one-entry holding register. The engine copies it into a shift register when it begins the next byte on the bus. The first byte after a start is the slave address with its R/W bit, and that byte goes through the same port as data bytes. The back-pressure rule is as follows. `tx_ready` is high exactly when the holding register is empty. A byte is taken on a clock edge where both `tx_valid` and `tx_ready` are high. `tx_data` only has to be stable during that cycle.

Each byte occupies nine SCL periods. The first eight carry the byte, most significant bit first. In the ninth, the master releases SDA so the slave can answer. The answer is latched into an acknowledge status bit. When the byte ends, a sticky interrupt flag is raised and SCL is held low. The next byte does not start until the host clears that flag. SCL and SDA are open-drain lines, modelled as active-high pull-down enables.

Top module: `i2c_master_tx`

## Requirements
- R1: After reset both line enables are 0 (lines released), `bus_busy`, `irq` and `ack_stat` are 0, and `tx_ready` is 1.
- R2: In idle, a command write with `cmd_busy`=1 and `cmd_ss`=0 pulls SDA low while SCL stays released, then sets `bus_busy`. The pairs {1,1} and {0,0} written in idle leave both lines released and `bus_busy` at 0.
- R3: A handshake on the transmit port drops `tx_ready` on the next cycle. `tx_ready` returns to 1 one cycle after the engine copies the byte into its shift register. That copy only happens in the inter-byte wait, and only while the flag is clear.
- R4: A byte takes nine SCL high pulses. Pulses 1 to 8 present bits 7 down to 0, and in pulse 9 the master releases SDA. During a byte, SDA never changes while SCL is high.
- R5: Every SCL high and low phase inside a byte lasts exactly `HALF_CYC` system clocks.
- R6: SDA is sampled in the middle of the ninth high phase into `ack_stat`. A value of 0 means acknowledged and 1 means not acknowledged.
- R7: At the end of the ninth pulse, `irq` is set and SCL is held low. `irq` stays set until `irq_clr` is asserted, and no byte starts while it is set. If the set and `irq_clr` fall in the same cycle, the set wins.
- R8: Writing 0 through the acknowledge-enable write clears `ack_stat`. Writing 1 leaves it unchanged.
- R9: A command write of {0,0} during the inter-byte wait produces the stop sequence. SCL is released while SDA is held low, and then SDA is released. After that, `bus_busy` returns to 0 and both lines stay released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_busy | input | 1 | Bus-busy command bit |
| cmd_ss | input | 1 | Start/stop-enable command bit |
| acken_wr | input | 1 | Acknowledge-enable write strobe |
| acken_val | input | 1 | Acknowledge-enable value written |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Holding register empty |
| tx_data | input | DW | Transmit byte |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq | output | 1 | Sticky end-of-byte interrupt flag |
| ack_stat | output | 1 | Captured acknowledge (1 = no acknowledge) |
| bus_busy | output | 1 | Transfer in progress |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
The end-of-byte flag set and the host's flag clear can land in the same clock edge. The bench provokes this by holding `irq_clr` high for an entire byte, so the clear is still active when the ninth pulse ends. The set must win. The bench therefore expects `irq` to read high for exactly one cycle and then be cleared by the still-asserted clear. A one-cycle pulse passes; zero cycles or a flag that sticks is reported.

// File: rtl/i2c_mtx_pkg.sv
package i2c_mtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HOLD, ST_BLO, ST_BHI, ST_STOPA, ST_STOPB, ST_STOPC
  } mtx_state_e;
endpackage

// File: rtl/i2c_mtx_tick.sv
// Half-period timebase: counts system clocks while a timed phase runs.
module i2c_mtx_tick #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last,
  output logic mid
);
  localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(HALF - 1);
  localparam logic [CW-1:0] MID_V  = CW'(HALF / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || last)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign last = run && (cnt_q == LAST_V);
  assign mid  = run && (cnt_q == MID_V);

  AST_NO_BACK_TO_BACK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !last); // R5
endmodule

// File: rtl/i2c_mtx_hold.sv
// One-entry transmit holding register with a valid/ready input side.
module i2c_mtx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          take,
  output logic [DW-1:0] out_data,
  output logic          full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      out_data <= '0;
    end else if (in_valid && in_ready) begin
      full     <= 1'b1;
      out_data <= in_data;
    end else if (take) begin
      full     <= 1'b0;
    end
  end

  assign in_ready = !full;

  AST_TAKE_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full); // R3
  AST_ACCEPT_BLOCKS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R3
endmodule

// File: rtl/i2c_master_tx.sv
module i2c_master_tx #(
  parameter int HALF_CYC = 4,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          cmd_busy,
  input  logic          cmd_ss,
  input  logic          acken_wr,
  input  logic          acken_val,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          irq_clr,
  output logic          irq,
  output logic          ack_stat,
  output logic          bus_busy,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_in
);
  import i2c_mtx_pkg::*;

  localparam int BCW = $clog2(DW + 1);
  localparam logic [BCW-1:0] SLOT = BCW'(DW);

  mtx_state_e     st_q, st_d;
  logic [DW-1:0]  sh_q;
  logic [BCW-1:0] bcnt_q;
  logic           flag_q, ack_q, busy_q;
  logic           load, t_run, t_last, t_mid;
  logic           hold_full;
  logic [DW-1:0]  hold_data;
  logic           byte_end, cmd_start, cmd_stop;

  assign cmd_start = cmd_wr &&  cmd_busy && !cmd_ss;
  assign cmd_stop  = cmd_wr && !cmd_busy && !cmd_ss;

  assign t_run = (st_q != ST_IDLE) && (st_q != ST_HOLD);

  i2c_mtx_tick #(.HALF(HALF_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(t_run), .last(t_last), .mid(t_mid)
  );

  i2c_mtx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(tx_valid), .in_ready(tx_ready),
    .in_data(tx_data), .take(load), .out_data(hold_data), .full(hold_full)
  );

  assign byte_end = (st_q == ST_BHI) && t_last && (bcnt_q == SLOT);

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    case (st_q)
      ST_IDLE:  if (cmd_start) st_d = ST_START;
      ST_START: if (t_last) st_d = ST_HOLD;
      ST_HOLD: begin
        if (cmd_stop) st_d = ST_STOPA;
        else if (!flag_q && hold_full) begin
          load = 1'b1;
          st_d = ST_BLO;
        end
      end
      ST_BLO:   if (t_last) st_d = ST_BHI;
      ST_BHI:   if (t_last) st_d = (bcnt_q == SLOT) ? ST_HOLD : ST_BLO;
      ST_STOPA: if (t_last) st_d = ST_STOPB;
      ST_STOPB: if (t_last) st_d = ST_STOPC;
      ST_STOPC: if (t_last) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      bcnt_q <= '0;
      flag_q <= 1'b0;
      ack_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load) begin
        sh_q   <= hold_data;
        bcnt_q <= '0;
      end else if ((st_q == ST_BHI) && t_last && (bcnt_q != SLOT)) begin
        sh_q   <= {sh_q[DW-2:0], 1'b0};
        bcnt_q <= bcnt_q + 1'b1;
      end
      if (byte_end)     flag_q <= 1'b1;
      else if (irq_clr) flag_q <= 1'b0;
      if ((st_q == ST_BHI) && t_mid && (bcnt_q == SLOT)) ack_q <= sda_in;
      else if (acken_wr && !acken_val)                   ack_q <= 1'b0;
      if ((st_q == ST_IDLE) && cmd_start)      busy_q <= 1'b1;
      else if ((st_q == ST_STOPC) && t_last)   busy_q <= 1'b0;
    end
  end

  assign scl_oe = (st_q == ST_HOLD) || (st_q == ST_BLO) || (st_q == ST_STOPA);

  always_comb begin
    case (st_q)
      ST_START, ST_HOLD, ST_STOPA, ST_STOPB: sda_oe = 1'b1;
      ST_BLO, ST_BHI: sda_oe = (bcnt_q == SLOT) ? 1'b0 : !sh_q[DW-1];
      default: sda_oe = 1'b0;
    endcase
  end

  assign irq      = flag_q;
  assign ack_stat = ack_q;
  assign bus_busy = busy_q;

  AST_SDA_STEADY_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_BHI) && ($past(st_q) == ST_BHI)) |-> $stable(sda_oe)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R7
  AST_FLAG_GATES_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_HOLD) && irq) |=> ((st_q == ST_HOLD) || (st_q == ST_STOPA))); // R7
  AST_ACK_CHANGES_ONLY_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_stat) |-> (($past(st_q) == ST_BHI) || $past(acken_wr))); // R6
  AST_IDLE_LINES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |-> (!scl_oe && !sda_oe)); // R9
endmodule

// File: tb/i2c_master_tx_test.sv
`timescale 1ns/1ps
module i2c_master_tx_test;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 0, cmd_busy = 0, cmd_ss = 0, acken_wr = 0, acken_val = 0;
  logic tx_valid = 0, irq_clr = 0;
  logic [7:0] tx_data = '0;
  logic tx_ready, irq, ack_stat, bus_busy, scl_oe, sda_oe, sda_in;

  always #2.5 clk = ~clk;

  logic slv_pull = 1'b0;
  logic slave_acks = 1'b1;
  assign sda_in = !sda_oe && !slv_pull;

  i2c_master_tx #(.HALF_CYC(HALF), .DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_busy(cmd_busy), .cmd_ss(cmd_ss),
    .acken_wr(acken_wr), .acken_val(acken_val), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .irq_clr(irq_clr), .irq(irq), .ack_stat(ack_stat),
    .bus_busy(bus_busy), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  int tests = 0, fails = 0;
  int starts = 0, stops = 0, glitches = 0, bad_hi = 0, bytes = 0, rises = 0;
  int bitn = 0, hi_run = 0;
  bit meas = 0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic [7:0] shreg = '0, rx_byte = '0;

  // Bus monitor and slave model, sampled on the falling clock edge.
  always @(negedge clk) begin
    logic scl_l, sda_l;
    scl_l = !scl_oe;
    sda_l = sda_in;
    if (rst_n) begin
      if (p_scl && scl_l && p_sda && !sda_l) begin starts++; bitn = 0; end
      else if (p_scl && scl_l && !p_sda && sda_l) stops++;
      else if (meas && p_scl && scl_l && (p_sda != sda_l)) glitches++;
      if (!p_scl && scl_l) begin
        rises++;
        hi_run = 0;
        if (bitn < 8) shreg = {shreg[6:0], sda_l};
        bitn++;
        if (bitn == 9) begin rx_byte = shreg; bytes++; bitn = 0; end
      end
      if (scl_l) hi_run++;
      if (p_scl && !scl_l) begin
        if (meas && hi_run != HALF) bad_hi++;
        slv_pull <= (bitn == 8) && slave_acks;
      end
    end
    p_scl = scl_l;
    p_sda = sda_l;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic command(input logic b, input logic s);
    @(negedge clk); cmd_wr = 1; cmd_busy = b; cmd_ss = s;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic wait_irq();
    int n = 0;
    while (!irq && n < 2000) begin @(negedge clk); n++; end
    chk(irq == 1'b1, "R7 irq after byte", int'(irq), 1);
  endtask

  task automatic clear_flag();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk(irq == 1'b0, "R7 flag cleared", int'(irq), 0);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({scl_oe, sda_oe} == 2'b00, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk({bus_busy, irq, ack_stat} == 3'b000, "R1 status clear", {bus_busy, irq, ack_stat}, 0);
    chk(tx_ready == 1'b1, "R1 ready", int'(tx_ready), 1);
  endtask

  task automatic t_ignored_cmds();
    command(1, 1);
    command(0, 0);
    repeat (20) @(negedge clk);
    chk(bus_busy == 1'b0 && starts == 0, "R2 other pairs ignored", starts, 0);
    chk({scl_oe, sda_oe} == 2'b00, "R2 lines stay released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_start();
    command(1, 0);
    repeat (2 * HALF + 4) @(negedge clk);
    chk(starts == 1, "R2 start condition", starts, 1);
    chk(bus_busy == 1'b1, "R2 busy set", int'(bus_busy), 1);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit nack);
    int b0;
    slave_acks = !nack;
    clear_flag();
    b0 = bytes; meas = 1; bad_hi = 0; glitches = 0;
    chk(tx_ready == 1'b1, "R3 ready before write", int'(tx_ready), 1);
    tx_valid = 1; tx_data = d;
    @(negedge clk); tx_valid = 0;
    chk(tx_ready == 1'b0, "R3 ready drops", int'(tx_ready), 0);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R3 ready after copy", int'(tx_ready), 1);
    wait_irq();
    meas = 0;
    chk(bytes == b0 + 1 && rx_byte == d, "R4 byte on bus", int'(rx_byte), int'(d));
    chk(glitches == 0, "R4 SDA steady while SCL high", glitches, 0);
    chk(bad_hi == 0, "R5 high phase length", bad_hi, 0);
    chk(ack_stat == nack, "R6 ack status", int'(ack_stat), int'(nack));
    chk(scl_oe == 1'b1, "R7 SCL held low", int'(scl_oe), 1);
  endtask

  task automatic t_flag_blocks();
    int r0;
    repeat (20) @(negedge clk);
    chk(irq == 1'b1, "R7 flag stays set", int'(irq), 1);
    r0 = rises;
    tx_valid = 1; tx_data = 8'h3C;
    @(negedge clk); tx_valid = 0;
    repeat (30) @(negedge clk);
    chk(tx_ready == 1'b0 && rises == r0, "R7 no byte while flag set", rises - r0, 0);
    meas = 1; bad_hi = 0;
    clear_flag();
    wait_irq();
    meas = 0;
    chk(rx_byte == 8'h3C, "R4 byte after clear", int'(rx_byte), 8'h3C);
    chk(bad_hi == 0, "R5 phase length second byte", bad_hi, 0);
  endtask

  task automatic t_same_cycle();
    int hi = 0;
    tx_valid = 1; tx_data = 8'h5A;
    @(negedge clk); tx_valid = 0;
    irq_clr = 1;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (irq) hi++;
    end
    irq_clr = 0;
    chk(hi == 1, "R7 set wins over clear", hi, 1);
    chk(rx_byte == 8'h5A, "R4 byte with clear held", int'(rx_byte), 8'h5A);
  endtask

  task automatic t_acken();
    @(negedge clk); acken_wr = 1; acken_val = 1;
    @(negedge clk); acken_wr = 0;
    chk(ack_stat == 1'b1, "R8 write 1 keeps status", int'(ack_stat), 1);
    acken_wr = 1; acken_val = 0;
    @(negedge clk); acken_wr = 0;
    chk(ack_stat == 1'b0, "R8 write 0 clears status", int'(ack_stat), 0);
  endtask

  task automatic t_stop();
    clear_flag();
    command(0, 0);
    repeat (3 * HALF + 4) @(negedge clk);
    chk(stops == 1, "R9 stop condition", stops, 1);
    chk(bus_busy == 1'b0, "R9 busy cleared", int'(bus_busy), 0);
    chk({scl_oe, sda_oe} == 2'b00 && tx_ready, "R9 lines released", {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    t_reset();
    t_ignored_cmds();
    t_start();
    send_byte(8'hA4, 1'b0);
    t_flag_blocks();
    t_same_cycle();
    send_byte(8'h96, 1'b1);
    t_acken();
    t_stop();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule